// File: doc/BRIEF.md
# DDR SDRAM Command Spacing Checker

This block watches the command bus between a DDR SDRAM controller and its memory devices. Every clock it decodes the chip select, the row, column and write strobes, the auto-precharge address bit, the two bank-select bits and the clock-enable level. From the decoded commands it tracks which of the four banks hold an open row. Separate countdown timers record how long ago each command that limits a later one was issued. When a command arrives before its minimum spacing has passed, or addresses a bank in the wrong state, the block raises a one-cycle violation pulse with a code naming the broken rule.

Burst length and CAS latency are static inputs. The spacings that depend on them are worked out from those inputs. Once a command is flagged, the checker still updates its state as if the command had been accepted, so it can keep monitoring a controller that has gone wrong. The block is meant as a simulation or silicon-side guard next to a controller. It drives nothing back onto the memory bus.

Top module: `ddrchk_top`

## Requirements
- R1: Commands are decoded from {rasN,casN,weN}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 110 burst stop, 111 no-op. A command counts only when csN is low and cke is high in that cycle.
- R2: While csN is high, every command input is ignored. Bank open state and all running timers carry on unchanged, and no violation is raised.
- R3: The bank index is {ba[0], ba[1]}: ba=2'b00 is bank 0, 2'b10 is bank 1, 2'b01 is bank 2, 2'b11 is bank 3.
- R4: Activate opens the addressed bank. Precharge with a10 low closes the addressed bank, and with a10 high closes all four banks. Read or write with a10 high closes the bank after the access; with a10 low the bank stays open.
- R5: A read or write to a closed bank gives code 1. An activate to an open bank gives code 2. The bank state is still updated as if the command had been accepted.
- R6: A precharge reaching a bank fewer than 3+BL/2 cycles after a write to that bank gives code 3. One fewer than BL/2 cycles after a read to it gives code 4. Precharge-all checks every bank, and other banks do not interfere.
- R7: A read fewer than 2+BL/2 cycles after any write gives code 5.
- R8: A write after any read gives code 6 when the gap is below 2+BL/2 cycles with casLatX2=4 (CL 2), or below 3+BL/2 cycles with casLatX2=5 (CL 2.5).
- R9: A write fewer than 2 cycles (casLatX2=4) or 3 cycles (casLatX2=5) after a burst stop gives code 7.
- R10: An activate or a mode-register set fewer than 2 cycles after a mode-register set gives code 8.
- R11: A refresh with cke low enters self refresh. Commands are not decoded while cke stays low. The cycle in which cke returns high is exit cycle e. A non-read command before e+10 gives code 9, and a read before e+200 gives code 10.
- R12: Spacing is counted from command cycle t, so a gap of N allows the next command at t+N. violValid is high for exactly the cycle after the offending command, and violCode then holds the smallest applicable code. Both outputs are 0 otherwise and after reset, and reset leaves all banks closed and all timers cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| a10 | input | 1 | Auto-precharge / precharge-all bit |
| ba | input | 2 | Bank select bits (ba[1], ba[0]) |
| cke | input | 1 | Clock enable level |
| burstLen | input | 4 | Burst length: 2, 4 or 8 |
| casLatX2 | input | 3 | CAS latency doubled: 4 or 5 |
| violValid | output | 1 | One-cycle violation pulse |
| violCode | output | 4 | Code of the rule broken, 0 when none |

## Verification
Each command is sampled at one rising edge, and its verdict is registered at that same edge, so the verdict is on the outputs one cycle later. The bench drives each command on the falling edge and reads violValid and violCode shortly after the next rising edge. Every spacing rule is tested in pairs: the second command is placed one cycle inside the minimum gap, which must report the rule's code, and exactly at the gap, which must report nothing. The gaps are counted as command cycles between the two issues, and the gap values are taken from the requirements for the configured burst length and latency. For self refresh, the exit cycle is counted as e, and the two guard windows are probed at e+9/e+10 and e+199/e+200.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmdE;

  localparam int BANKS  = 4;
  localparam int BANK_W = 2;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] VC_NONE     = 4'd0;
  localparam logic [CODE_W-1:0] VC_CLOSED   = 4'd1;
  localparam logic [CODE_W-1:0] VC_OPEN     = 4'd2;
  localparam logic [CODE_W-1:0] VC_WR_PRE   = 4'd3;
  localparam logic [CODE_W-1:0] VC_RD_PRE   = 4'd4;
  localparam logic [CODE_W-1:0] VC_WR_RD    = 4'd5;
  localparam logic [CODE_W-1:0] VC_RD_WR    = 4'd6;
  localparam logic [CODE_W-1:0] VC_BST_WR   = 4'd7;
  localparam logic [CODE_W-1:0] VC_MRS_GAP  = 4'd8;
  localparam logic [CODE_W-1:0] VC_SR_OTHER = 4'd9;
  localparam logic [CODE_W-1:0] VC_SR_READ  = 4'd10;

  // Decoded command strobes handed from control to datapath.
  typedef struct packed {
    logic              anyCmd;
    logic              act;
    logic              rd;
    logic              wr;
    logic              pre;
    logic              preAll;
    logic              mrs;
    logic              bst;
    logic              autoPre;
    logic              srExit;
    logic [BANK_W-1:0] bank;
  } strobeT;

endpackage

// File: rtl/ddrchk_timer.sv
module ddrchk_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         busy
);

  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (load)          count <= loadVal;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign busy = (count != '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (!load && busy) |=> (count == W'($past(count) - 1'b1))); // R12

endmodule

// File: rtl/ddrchk_ctrl.sv
module ddrchk_ctrl
  import ddrchk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        a10,
  input  logic [1:0]  ba,
  input  logic        cke,
  output strobeT      strobe
);

  cmdE  cmd;
  logic live;
  logic srActive;
  logic srEnter;
  logic srExit;
  logic isRef;

  assign cmd  = cmdE'({rasN, casN, weN});
  assign live = !csN && cke;

  assign srEnter = !csN && !cke && !srActive && (cmd == CMD_REF);
  assign srExit  = srActive && cke;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        srActive <= 1'b0;
    else if (srEnter) srActive <= 1'b1;
    else if (srExit)  srActive <= 1'b0;
  end

  assign isRef = live && (cmd == CMD_REF);

  always_comb begin
    strobe.anyCmd  = live && (cmd != CMD_NOP);
    strobe.act     = live && (cmd == CMD_ACT);
    strobe.rd      = live && (cmd == CMD_RD);
    strobe.wr      = live && (cmd == CMD_WR);
    strobe.pre     = live && (cmd == CMD_PRE);
    strobe.preAll  = a10;
    strobe.mrs     = live && (cmd == CMD_MRS);
    strobe.bst     = live && (cmd == CMD_BST);
    strobe.autoPre = a10;
    strobe.srExit  = srExit;
    strobe.bank    = {ba[0], ba[1]};
  end

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.act, strobe.rd, strobe.wr, strobe.pre, isRef, strobe.mrs, strobe.bst})); // R1
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !strobe.anyCmd); // R2
  AST_SELFREF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (srActive && !cke) |-> !strobe.anyCmd); // R11

endmodule

// File: rtl/ddrchk_dp.sv
module ddrchk_dp
  import ddrchk_pkg::*;
#(
  parameter int TW          = 8,
  parameter int MRS_GAP     = 2,
  parameter int SR_NONRD    = 10,
  parameter int SR_RD       = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [3:0]        burstLen,
  input  logic [2:0]        casLatX2,
  output logic              violValid,
  output logic [CODE_W-1:0] violCode
);

  logic [TW-1:0] half;
  logic          clSlow;
  logic [TW-1:0] ldWrPre, ldRdPre, ldWrRd, ldRdWr, ldBstWr;
  localparam logic [TW-1:0] LD_MRS  = TW'(MRS_GAP - 1);
  localparam logic [TW-1:0] LD_SR_N = TW'(SR_NONRD - 1);
  localparam logic [TW-1:0] LD_SR_R = TW'(SR_RD - 1);

  assign half    = TW'(burstLen) >> 1;
  assign clSlow  = (casLatX2 == 3'd5);
  assign ldWrPre = TW'(2) + half;
  assign ldRdPre = half - TW'(1);
  assign ldWrRd  = TW'(1) + half;
  assign ldRdWr  = clSlow ? (TW'(2) + half) : (TW'(1) + half);
  assign ldBstWr = clSlow ? TW'(2) : TW'(1);

  logic [BANKS-1:0] bankOpen;
  logic [BANKS-1:0] wrPreBusy, rdPreBusy, wrPreHit, rdPreHit;

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    logic hit;
    logic preTarget;
    assign hit       = (strobe.bank == BANK_W'(b));
    assign preTarget = strobe.pre && (strobe.preAll || hit);

    ddrchk_timer #(.W(TW)) uWrPre (
      .clk(clk), .rstN(rstN), .load(strobe.wr && hit),
      .loadVal(ldWrPre), .busy(wrPreBusy[b]));
    ddrchk_timer #(.W(TW)) uRdPre (
      .clk(clk), .rstN(rstN), .load(strobe.rd && hit),
      .loadVal(ldRdPre), .busy(rdPreBusy[b]));

    assign wrPreHit[b] = preTarget && wrPreBusy[b];
    assign rdPreHit[b] = preTarget && rdPreBusy[b];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                            bankOpen[b] <= 1'b0;
      else if (strobe.act && hit)                           bankOpen[b] <= 1'b1;
      else if (preTarget)                                   bankOpen[b] <= 1'b0;
      else if ((strobe.rd || strobe.wr) && hit && strobe.autoPre) bankOpen[b] <= 1'b0;
    end
  end

  logic wrRdBusy, rdWrBusy, bstBusy, mrsBusy, srNBusy, srRBusy;

  ddrchk_timer #(.W(TW)) uWrRd (.clk(clk), .rstN(rstN), .load(strobe.wr),
    .loadVal(ldWrRd), .busy(wrRdBusy));
  ddrchk_timer #(.W(TW)) uRdWr (.clk(clk), .rstN(rstN), .load(strobe.rd),
    .loadVal(ldRdWr), .busy(rdWrBusy));
  ddrchk_timer #(.W(TW)) uBstWr (.clk(clk), .rstN(rstN), .load(strobe.bst),
    .loadVal(ldBstWr), .busy(bstBusy));
  ddrchk_timer #(.W(TW)) uMrs (.clk(clk), .rstN(rstN), .load(strobe.mrs),
    .loadVal(LD_MRS), .busy(mrsBusy));
  ddrchk_timer #(.W(TW)) uSrN (.clk(clk), .rstN(rstN), .load(strobe.srExit),
    .loadVal(LD_SR_N), .busy(srNBusy));
  ddrchk_timer #(.W(TW)) uSrR (.clk(clk), .rstN(rstN), .load(strobe.srExit),
    .loadVal(LD_SR_R), .busy(srRBusy));

  logic              selOpen;
  logic [CODE_W-1:0] code;

  assign selOpen = bankOpen[strobe.bank];

  always_comb begin
    if ((strobe.rd || strobe.wr) && !selOpen)                   code = VC_CLOSED;
    else if (strobe.act && selOpen)                             code = VC_OPEN;
    else if (|wrPreHit)                                         code = VC_WR_PRE;
    else if (|rdPreHit)                                         code = VC_RD_PRE;
    else if (strobe.rd && wrRdBusy)                             code = VC_WR_RD;
    else if (strobe.wr && rdWrBusy)                             code = VC_RD_WR;
    else if (strobe.wr && bstBusy)                              code = VC_BST_WR;
    else if ((strobe.act || strobe.mrs) && mrsBusy)             code = VC_MRS_GAP;
    else if (strobe.anyCmd && !strobe.rd && (strobe.srExit || srNBusy)) code = VC_SR_OTHER;
    else if (strobe.rd && (strobe.srExit || srRBusy))           code = VC_SR_READ;
    else                                                        code = VC_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violValid <= 1'b0;
      violCode  <= VC_NONE;
    end else begin
      violValid <= (code != VC_NONE);
      violCode  <= code;
    end
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act |=> bankOpen[$past(strobe.bank)]); // R4
  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pre && strobe.preAll) |=> (bankOpen == '0)); // R4
  AST_WR_PRE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (|wrPreHit) |=> violValid); // R6
  AST_SR_READ_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rd && srRBusy) |=> (violValid && violCode != VC_NONE)); // R11
  AST_CODE_PAIRING: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> (violCode != VC_NONE)); // R12

endmodule

// File: rtl/ddrchk_top.sv
module ddrchk_top
  import ddrchk_pkg::*;
#(
  parameter int TW       = 8,
  parameter int MRS_GAP  = 2,
  parameter int SR_NONRD = 10,
  parameter int SR_RD    = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       a10,
  input  logic [1:0] ba,
  input  logic       cke,
  input  logic [3:0] burstLen,
  input  logic [2:0] casLatX2,
  output logic       violValid,
  output logic [3:0] violCode
);

  strobeT strobe;

  ddrchk_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .a10(a10), .ba(ba), .cke(cke), .strobe(strobe));

  ddrchk_dp #(.TW(TW), .MRS_GAP(MRS_GAP), .SR_NONRD(SR_NONRD), .SR_RD(SR_RD)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .burstLen(burstLen),
    .casLatX2(casLatX2), .violValid(violValid), .violCode(violCode));

endmodule

// File: tb/ddrchk_top_test.sv
module ddrchk_top_test;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011;
  localparam logic [2:0] C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1, a10 = 1'b0, cke = 1'b1;
  logic [1:0] ba = 2'b00;
  logic [3:0] burstLen = 4'd4;
  logic [2:0] casLatX2 = 3'd4;
  logic violValid;
  logic [3:0] violCode;

  logic ckeLvl = 1'b1;
  logic csLvl  = 1'b0;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ddrchk_top uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .a10(a10), .ba(ba), .cke(cke), .burstLen(burstLen), .casLatX2(casLatX2),
    .violValid(violValid), .violCode(violCode));

  task automatic checkOut(input logic [3:0] exp, input string tag);
    checks++;
    if (violValid !== (exp != 4'd0) || violCode !== exp) begin
      fails++;
      $display("FAIL %s: valid=%0b code=%0d, expected valid=%0b code=%0d",
               tag, violValid, violCode, (exp != 4'd0), exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] c, input logic hi, input logic [1:0] bsel,
                       input logic [3:0] exp, input string tag);
    @(negedge clk);
    {rasN, casN, weN} = c; a10 = hi; ba = bsel; cke = ckeLvl; csN = csLvl;
    @(posedge clk);
    #2;
    checkOut(exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {rasN, casN, weN} = C_NOP; a10 = 1'b0; cke = ckeLvl; csN = 1'b0;
      @(posedge clk);
      #2;
    end
  endtask

  task automatic resetDut(input logic [3:0] bl, input logic [2:0] cl);
    @(negedge clk);
    rstN = 1'b0; burstLen = bl; casLatX2 = cl;
    ckeLvl = 1'b1; csLvl = 1'b0;
    {rasN, casN, weN} = C_NOP; cke = 1'b1; csN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset;
    resetDut(4'd4, 3'd4);
    @(posedge clk); #2;
    checkOut(4'd0, "R12 reset outputs");
  endtask

  task automatic testDecodeBank;   // R1 R3 R5
    resetDut(4'd4, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b10, 4'd0, "R1 activate bank1");
    idle(1);
    doCmd(C_RD,  1'b0, 2'b10, 4'd0, "R3 read ba=10 hits bank1");
    idle(1);
    doCmd(C_RD,  1'b0, 2'b01, 4'd1, "R3 read ba=01 is closed bank2");
    doCmd(C_ACT, 1'b0, 2'b10, 4'd2, "R5 activate open bank");
    doCmd(C_ACT, 1'b0, 2'b01, 4'd0, "R5 activate closed bank2");
  endtask

  task automatic testDeselect;     // R2
    resetDut(4'd4, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b10, 4'd0, "R2 setup activate");
    csLvl = 1'b1;
    doCmd(C_PRE, 1'b1, 2'b00, 4'd0, "R2 deselected precharge-all");
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R2 deselected activate");
    csLvl = 1'b0;
    doCmd(C_RD,  1'b0, 2'b10, 4'd0, "R2 bank1 still open");
    doCmd(C_RD,  1'b0, 2'b00, 4'd1, "R2 bank0 still closed");
  endtask

  task automatic testPrecharge;    // R4 R6, BL=4
    resetDut(4'd4, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R4 activate bank0");
    idle(1);
    doCmd(C_WR,  1'b0, 2'b00, 4'd0, "R6 write bank0");
    idle(3);
    doCmd(C_PRE, 1'b0, 2'b00, 4'd3, "R6 precharge 4 after write");
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R4 bank closed by flagged precharge");
    idle(1);
    doCmd(C_WR,  1'b0, 2'b00, 4'd0, "R6 write bank0 again");
    idle(4);
    doCmd(C_PRE, 1'b0, 2'b00, 4'd0, "R6 precharge 5 after write");
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R4 reopen bank0");
    doCmd(C_RD,  1'b0, 2'b00, 4'd0, "R6 read bank0");
    doCmd(C_PRE, 1'b1, 2'b00, 4'd4, "R6 precharge-all 1 after read");
    idle(5);
    doCmd(C_RD,  1'b0, 2'b00, 4'd1, "R4 precharge-all closed bank0");
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R6 activate bank0");
    doCmd(C_ACT, 1'b0, 2'b11, 4'd0, "R6 activate bank3");
    idle(1);
    doCmd(C_WR,  1'b0, 2'b00, 4'd0, "R6 write bank0 only");
    doCmd(C_PRE, 1'b0, 2'b11, 4'd0, "R6 precharge other bank unaffected");
  endtask

  task automatic testAutoPre;      // R4
    resetDut(4'd4, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b10, 4'd0, "R4 activate bank1");
    idle(1);
    doCmd(C_WR,  1'b1, 2'b10, 4'd0, "R4 write with auto-precharge");
    idle(6);
    doCmd(C_RD,  1'b0, 2'b10, 4'd1, "R4 bank closed after auto-precharge");
  endtask

  task automatic testWrRd;         // R7, BL=8
    resetDut(4'd8, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R7 activate bank0");
    doCmd(C_ACT, 1'b0, 2'b01, 4'd0, "R7 activate bank2");
    idle(1);
    doCmd(C_WR,  1'b0, 2'b00, 4'd0, "R7 write bank0");
    idle(4);
    doCmd(C_RD,  1'b0, 2'b01, 4'd5, "R7 read 5 after write");
    idle(9);
    doCmd(C_WR,  1'b0, 2'b00, 4'd0, "R7 write bank0 again");
    idle(5);
    doCmd(C_RD,  1'b0, 2'b00, 4'd0, "R7 read 6 after write");
  endtask

  task automatic testRdWr;         // R8, BL=4
    resetDut(4'd4, 3'd5);
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R8 activate bank0");
    idle(1);
    doCmd(C_RD,  1'b0, 2'b00, 4'd0, "R8 read bank0");
    idle(3);
    doCmd(C_WR,  1'b0, 2'b00, 4'd6, "R8 write 4 after read at CL2.5");
    resetDut(4'd4, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R8 activate bank0");
    idle(1);
    doCmd(C_RD,  1'b0, 2'b00, 4'd0, "R8 read bank0");
    idle(3);
    doCmd(C_WR,  1'b0, 2'b00, 4'd0, "R8 write 4 after read at CL2");
  endtask

  task automatic testBurstStop;    // R9
    resetDut(4'd4, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R9 activate bank0");
    idle(1);
    doCmd(C_BST, 1'b0, 2'b00, 4'd0, "R9 burst stop");
    doCmd(C_WR,  1'b0, 2'b00, 4'd7, "R9 write 1 after stop CL2");
    idle(4);
    doCmd(C_BST, 1'b0, 2'b00, 4'd0, "R9 burst stop again");
    idle(1);
    doCmd(C_WR,  1'b0, 2'b00, 4'd0, "R9 write 2 after stop CL2");
    resetDut(4'd4, 3'd5);
    doCmd(C_ACT, 1'b0, 2'b00, 4'd0, "R9 activate bank0");
    idle(1);
    doCmd(C_BST, 1'b0, 2'b00, 4'd0, "R9 burst stop");
    idle(1);
    doCmd(C_WR,  1'b0, 2'b00, 4'd7, "R9 write 2 after stop CL2.5");
  endtask

  task automatic testModeReg;      // R10
    resetDut(4'd4, 3'd4);
    doCmd(C_MRS, 1'b0, 2'b00, 4'd0, "R10 mode set");
    doCmd(C_ACT, 1'b0, 2'b00, 4'd8, "R10 activate 1 after mode set");
    idle(3);
    doCmd(C_MRS, 1'b0, 2'b00, 4'd0, "R10 mode set again");
    doCmd(C_MRS, 1'b0, 2'b00, 4'd8, "R10 mode set 1 after mode set");
    idle(1);
    doCmd(C_ACT, 1'b0, 2'b10, 4'd0, "R10 activate 2 after mode set");
  endtask

  task automatic testSelfRefresh;  // R11
    resetDut(4'd4, 3'd4);
    doCmd(C_ACT, 1'b0, 2'b10, 4'd0, "R11 activate bank1");
    ckeLvl = 1'b0;
    doCmd(C_REF, 1'b0, 2'b00, 4'd0, "R11 self refresh entry");
    idle(2);
    doCmd(C_RD,  1'b0, 2'b10, 4'd0, "R11 command ignored while cke low");
    ckeLvl = 1'b1;
    doCmd(C_NOP, 1'b0, 2'b00, 4'd0, "R11 exit cycle");
    idle(8);
    doCmd(C_ACT, 1'b0, 2'b00, 4'd9, "R11 activate 9 after exit");
    doCmd(C_ACT, 1'b0, 2'b11, 4'd0, "R11 activate 10 after exit");
    doCmd(C_RD,  1'b0, 2'b10, 4'd10, "R11 read 11 after exit");
    idle(187);
    doCmd(C_RD,  1'b0, 2'b10, 4'd10, "R11 read 199 after exit");
    doCmd(C_RD,  1'b0, 2'b10, 4'd0, "R11 read 200 after exit");
  endtask

  initial begin
    testReset();
    testDecodeBank();
    testDeselect();
    testPrecharge();
    testAutoPre();
    testWrRd();
    testRdWr();
    testBurstStop();
    testModeReg();
    testSelfRefresh();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule